// File: doc/BRIEF.md
# Byte Parity Guard with Sticky Error Interrupt

This block sits between a byte-wide processor bus and a memory that stores nine bits per location: eight data bits and one parity bit. When the processor writes to memory, the block computes a parity bit from the data byte. That bit goes out on a dedicated lane and is stored beside the byte, so that every stored 9-bit word holds an odd number of ones.

When the processor reads from memory, the same 9-input parity function checks the 9-bit word coming back. If that word holds an even number of ones, the word is corrupt. The block samples this result into a sticky flag on the clock edge that ends the read. The flag drives a non-maskable interrupt request, and only the active-low reset clears it.

I/O cycles and writes never disturb the flag. The scheme catches any odd number of flipped bits. An even number of flips gives a word that still looks valid, so it passes unnoticed.

Top module: `parity_guard`

## Requirements
- R1: During a memory write, `mem_wpar_o` is 1 when `cpu_wdata_i` holds an even number of ones and 0 when it holds an odd number, so the 9-bit word {`mem_wpar_o`, `mem_wdata_o`} always has an odd count of ones.
- R2: `mem_we_o` is high only when `cpu_wr_i` is high and `cpu_mem_i` is 1 (1 = memory space, 0 = I/O space). `mem_re_o` is high only when `cpu_rd_i` is high, `cpu_wr_i` is low and `cpu_mem_i` is 1.
- R3: During a memory read, `cpu_rdata_o` equals `mem_rdata_i`. At all other times it is zero.
- R4: Consider a clock edge at which a memory read is in progress and {`mem_rpar_i`, `mem_rdata_i`} holds an even number of ones. `nmi_o` is 1 from that edge onward. Before that edge it is unchanged.
- R5: Once `nmi_o` is 1, it stays 1 through later error-free reads, writes and idle cycles until reset.
- R6: Write cycles and I/O read cycles never set `nmi_o`, whatever the memory read lanes carry.
- R7: Driving `rst_ni` low clears `nmi_o` at once, without waiting for a clock edge, and it holds 0 until the first bad memory read.
- R8: A stored word with exactly two flipped bits, in either data or parity, reads back as valid and leaves `nmi_o` at 0.
- R9: `mem_addr_o` follows `cpu_addr_i`, and `mem_wdata_o` follows `cpu_wdata_i`.
- R10: When `cpu_rd_i` and `cpu_wr_i` are both high in memory space, the cycle is treated as a write. No check is sampled and `mem_re_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_wdata_i | input | 8 | Write data from the processor |
| cpu_rdata_o | output | 8 | Read data to the processor |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 8 | Data lane to memory |
| mem_wpar_o | output | 1 | Parity lane to memory |
| mem_rdata_i | input | 8 | Data lane from memory |
| mem_rpar_i | input | 1 | Parity lane from memory |
| nmi_o | output | 1 | Sticky parity-error interrupt request |

## Verification
The flag is the only state in the block. If it is set wrongly, `nmi_o` shows it one edge after the offending cycle. If it fails to hold, `nmi_o` drops on the first cycle after it should have stayed high.

A wrong mux select on the shared parity function would show up on the write path as a wrong parity lane during the same cycle. On the read path it would appear as a missed or spurious interrupt at the next edge. Injected single-bit and double-bit faults in the memory model separate a correct odd-count check from an inverted or even-count one.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 1;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_MEM_RD = 2'd1,
    CYC_MEM_WR = 2'd2,
    CYC_IO     = 2'd3
  } cyc_e;
endpackage

// File: rtl/pg_parity_tree.sv
module pg_parity_tree #(
  parameter int unsigned N_IN = 9
) (
  input  logic [N_IN-1:0] bits_i,
  output logic            even_o,
  output logic            odd_o
);
  logic [N_IN-1:0] acc;

  assign acc[0] = bits_i[0];
  for (genvar i = 1; i < N_IN; i++) begin : g_chain
    assign acc[i] = acc[i-1] ^ bits_i[i];
  end

  assign odd_o  = acc[N_IN-1];
  assign even_o = ~acc[N_IN-1];
endmodule

// File: rtl/pg_cycle_dec.sv
module pg_cycle_dec
  import pg_pkg::*;
(
  input  logic cpu_mem_i,
  input  logic cpu_rd_i,
  input  logic cpu_wr_i,
  output cyc_e cyc_o,
  output logic mem_re_o,
  output logic mem_we_o
);
  always_comb begin
    if (!cpu_rd_i && !cpu_wr_i) cyc_o = CYC_IDLE;
    else if (!cpu_mem_i)        cyc_o = CYC_IO;
    else if (cpu_wr_i)          cyc_o = CYC_MEM_WR;  // write wins on overlap
    else                        cyc_o = CYC_MEM_RD;
  end

  assign mem_re_o = (cyc_o == CYC_MEM_RD);
  assign mem_we_o = (cyc_o == CYC_MEM_WR);
endmodule

// File: rtl/pg_err_latch.sv
module pg_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_en_i,
  input  logic err_i,
  output logic nmi_o
);
  logic nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 nmi_q <= 1'b0;
    else if (chk_en_i && err_i)  nmi_q <= 1'b1;
  end

  assign nmi_o = nmi_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |=> nmi_q);
  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && err_i) |=> nmi_q);
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_q && !(chk_en_i && err_i)) |=> !nmi_q);
endmodule

// File: rtl/parity_guard.sv
module parity_guard
  import pg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_mem_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [BYTE_W-1:0] cpu_wdata_i,
  output logic [BYTE_W-1:0] cpu_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_wpar_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              mem_rpar_i,
  output logic              nmi_o
);
  cyc_e              cyc;
  logic              is_rd;
  logic [WORD_W-1:0] tree_in;
  logic              tree_even;
  logic              tree_odd;

  pg_cycle_dec u_dec (
    .cpu_mem_i (cpu_mem_i),
    .cpu_rd_i  (cpu_rd_i),
    .cpu_wr_i  (cpu_wr_i),
    .cyc_o     (cyc),
    .mem_re_o  (mem_re_o),
    .mem_we_o  (mem_we_o)
  );

  assign is_rd = (cyc == CYC_MEM_RD);

  // one shared tree: ninth input is 0 when generating, stored parity when checking
  assign tree_in = is_rd ? {mem_rpar_i, mem_rdata_i} : {1'b0, cpu_wdata_i};

  pg_parity_tree #(.N_IN(WORD_W)) u_par (
    .bits_i (tree_in),
    .even_o (tree_even),
    .odd_o  (tree_odd)
  );

  assign mem_addr_o  = cpu_addr_i;
  assign mem_wdata_o = cpu_wdata_i;
  assign mem_wpar_o  = is_rd ? 1'b0 : tree_even;
  assign cpu_rdata_o = is_rd ? mem_rdata_i : '0;

  pg_err_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chk_en_i (is_rd),
    .err_i    (tree_even),
    .nmi_o    (nmi_o)
  );

  a_r1_odd_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (^{mem_wpar_o, mem_wdata_o}) == 1'b1);
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o}));
  a_r2_io_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_mem_i |-> !(mem_we_o || mem_re_o));
  a_r3_rd_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (cpu_rdata_o == mem_rdata_i) && !tree_odd == tree_even);
endmodule

// File: tb/parity_guard_tb_top.sv
module parity_guard_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80,
                                      8'h5A, 8'h7F, 8'hC3, 8'h10};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_mem = 1'b1, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, mem_wpar, mem_rpar, nmi;
  logic [7:0]    mem_wdata, mem_rdata;
  logic [8:0]    store [16];
  logic [8:0]    flip  [16];
  logic [8:0]    rd_word;
  int            checks = 0, failures = 0;

  always #10 clk = ~clk;

  parity_guard #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_mem_i(cpu_mem),
    .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_wdata_o(mem_wdata), .mem_wpar_o(mem_wpar),
    .mem_rdata_i(mem_rdata), .mem_rpar_i(mem_rpar), .nmi_o(nmi)
  );

  assign rd_word   = store[mem_addr[3:0]] ^ flip[mem_addr[3:0]];
  assign mem_rdata = rd_word[7:0];
  assign mem_rpar  = rd_word[8];

  always_ff @(posedge clk)
    if (mem_we) store[mem_addr[3:0]] <= {mem_wpar, mem_wdata};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, settle 5 ns for combinational checks
  task automatic drive(input logic mem, input logic rd, input logic wr,
                       input logic [3:0] a, input logic [7:0] d);
    cpu_mem = mem; cpu_rd = rd; cpu_wr = wr; cpu_addr = {{(AW-4){1'b0}}, a}; cpu_wdata = d;
    #5;
  endtask

  // pass the rising edge, return at next negedge with bus idle
  task automatic finish_cyc();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_mem = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin store[i] = 9'h100; flip[i] = '0; end
    repeat (2) @(negedge clk);
    // R7: reset state
    chk("R7 nmi in reset", nmi, 0);
    chk("R2 we idle", mem_we, 0);
    chk("R3 rdata idle", cpu_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: write then read each vector
    for (int i = 0; i < NV; i++) begin
      drive(1, 0, 1, i[3:0], VEC[i]);
      chk("R1 wpar", mem_wpar, ($countones(VEC[i]) % 2 == 0) ? 1 : 0);
      chk("R9 wdata/addr", {mem_wdata, mem_addr}, {VEC[i], 12'd0, i[3:0]});
      finish_cyc();
      drive(1, 1, 0, i[3:0], 8'h00);
      chk("R3 rdata", cpu_rdata, VEC[i]);
      chk("R2 re", {mem_re, mem_we}, 2'b10);
      finish_cyc();
      chk("R4 no error on clean word", nmi, 0);
    end

    // R6: I/O read of a corrupt location
    flip[2] = 9'h001;
    drive(0, 1, 0, 4'd2, 8'h00);
    chk("R2 io no strobes", {mem_re, mem_we}, 2'b00);
    finish_cyc();
    chk("R6 io read ignored", nmi, 0);
    // R6: write while read lanes are corrupt
    drive(1, 0, 1, 4'd2, VEC[2]);
    finish_cyc();
    chk("R6 write ignored", nmi, 0);
    // R10: rd and wr together in memory space
    drive(1, 1, 1, 4'd2, VEC[2]);
    chk("R10 overlap strobes", {mem_re, mem_we}, 2'b01);
    finish_cyc();
    chk("R10 overlap no check", nmi, 0);

    // R8: double flips pass
    flip[2] = 9'h003;
    drive(1, 1, 0, 4'd2, 8'h00); finish_cyc();
    chk("R8 two data bits", nmi, 0);
    flip[2] = 9'h180;
    drive(1, 1, 0, 4'd2, 8'h00); finish_cyc();
    chk("R8 parity+data bit", nmi, 0);
    flip[2] = '0;

    // R4: single flip in parity bit
    flip[5] = 9'h100;
    drive(1, 1, 0, 4'd5, 8'h00);
    chk("R4 not before edge", nmi, 0);
    finish_cyc();
    chk("R4 parity bit flip", nmi, 1);
    flip[5] = '0;

    // R5: sticky over good reads and idle
    drive(1, 1, 0, 4'd4, 8'h00); finish_cyc();
    chk("R5 after good read", nmi, 1);
    drive(1, 0, 1, 4'd4, 8'h33); finish_cyc();
    repeat (3) @(negedge clk);
    chk("R5 after write/idle", nmi, 1);

    // R7: asynchronous clear
    #3 rst_n = 1'b0;
    #1 chk("R7 async clear", nmi, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R7 held after reset", nmi, 0);

    // R4: single data-bit flip after reset
    flip[0] = 9'h010;
    drive(1, 1, 0, 4'd0, 8'h00); finish_cyc();
    chk("R4 data bit flip", nmi, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule